// File: doc/BRIEF.md
# Descriptor Indexed Access Resolver

This block turns an indexed reference through an array descriptor into either a physical word address, with a character lane inside that word, or a fault code. The caller presents a 48-bit descriptor word with its 3-bit type tag and an element index. The block checks that the tag marks a descriptor, checks the index against the array length held in the descriptor, and checks whether the segment is resident in main memory. It then works out which word holds the element and, for packed character strings, which character of that word holds it.

A descriptor can describe an array of whole words or a string of 4-, 6- or 8-bit characters. A 48-bit word holds 12, 8 or 6 such characters. The checks and the address arithmetic are combinational, and a single register stage holds the response, so the response appears one clock after the request. The memory, the allocation of descriptors and the fault handlers lie outside the block.

Top module: `dac_top`

## Requirements
- R1: `rsp_valid` rises exactly one clock after a cycle with `req_valid` high and is low one clock after a cycle with `req_valid` low. After reset all outputs read zero.
- R2: The descriptor tag value is 5. Any other `desc_tag` gives fault code 1 (wrong tag), whatever the other fields hold. This check has the highest priority.
- R3: The length field is `desc_word[39:20]` and counts elements. With a correct tag, `index >= length` gives fault code 2 (out of bounds). This includes every index when the length is 0, and the check applies whether or not the segment is present.
- R4: The presence bit is `desc_word[40]`. With a correct tag and an index in bounds, a clear presence bit gives fault code 3 (segment absent).
- R5: The mode field is `desc_word[42:41]`, and the base field is `desc_word[19:0]`. With mode 0 (word array) and no fault, the fault code is 0, `rsp_addr = base + index` and `rsp_lane = 0`.
- R6: With mode 1 (4-bit characters, 12 per word) and no fault, `rsp_addr = base + index/12` and `rsp_lane = index mod 12`.
- R7: With mode 2 (6-bit characters, 8 per word) and no fault, `rsp_addr = base + index/8` and `rsp_lane = index mod 8`.
- R8: With mode 3 (8-bit characters, 6 per word) and no fault, `rsp_addr = base + index/6` and `rsp_lane = index mod 6`.
- R9: A response that carries a nonzero fault code has `rsp_addr = 0` and `rsp_lane = 0`.
- R10: The address sum wraps modulo 2^20.
- R11: Descriptor bits 47:43 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is present this cycle |
| desc_tag | input | 3 | Type tag of the descriptor word |
| desc_word | input | 48 | Descriptor word: base, length, presence, mode |
| index | input | 20 | Element index into the array |
| rsp_valid | output | 1 | A registered response is present |
| rsp_fault | output | 2 | 0 none, 1 wrong tag, 2 out of bounds, 3 segment absent |
| rsp_addr | output | 20 | Physical word address |
| rsp_lane | output | 4 | Character position within the word |

## Verification
The assertions assume that the inputs hold known values and stay steady around the rising edge, because each one relates a request in one cycle to the response in the next. The bench drives every input on the falling edge and gives every input a defined value, including the cycles in which `req_valid` is low. The stimulus is kept inside the 3-bit tag and 20-bit index the ports allow, and it concentrates on the places where the behaviour changes: length zero, an index equal to the length, the last character of a word, and a base near the top of the address space.

// File: rtl/dac_pkg.sv
package dac_pkg;

   // Fault codes, listed in order of decreasing priority.
   typedef enum logic [1:0] {
      FLT_NONE   = 2'd0,
      FLT_TAG    = 2'd1,
      FLT_BOUNDS = 2'd2,
      FLT_ABSENT = 2'd3
   } fault_e;

   // Addressing modes held in the descriptor.
   typedef enum logic [1:0] {
      MODE_WORD = 2'd0,
      MODE_CH4  = 2'd1,
      MODE_CH6  = 2'd2,
      MODE_CH8  = 2'd3
   } mode_e;

endpackage

// File: rtl/dac_field_decode.sv
// Splits the descriptor into its fields and ranks the faults.
module dac_field_decode #(
   parameter int WORD_W = 48,
   parameter int TAG_W  = 3,
   parameter int ADDR_W = 20,
   parameter int LEN_W  = 20,
   parameter logic [TAG_W-1:0] DESC_TAG = 3'd5
) (
   input  logic [TAG_W-1:0]  tag,
   input  logic [WORD_W-1:0] word,
   input  logic [LEN_W-1:0]  idx,
   output logic [ADDR_W-1:0] base,
   output dac_pkg::mode_e    mode,
   output dac_pkg::fault_e   fault
);
   localparam int LEN_LSB  = ADDR_W;
   localparam int PRES_BIT = ADDR_W + LEN_W;
   localparam int MODE_LSB = PRES_BIT + 1;
   localparam int USED_W   = MODE_LSB + 2;

   logic [LEN_W-1:0] length;
   logic             present;

   assign base    = word[ADDR_W-1:0];
   assign length  = word[LEN_LSB +: LEN_W];
   assign present = word[PRES_BIT];
   assign mode    = dac_pkg::mode_e'(word[MODE_LSB +: 2]);

   generate
      if (USED_W < WORD_W) begin : g_spare
         logic spare_unused;
         assign spare_unused = ^word[WORD_W-1:USED_W];
      end
   endgenerate

   always_comb begin
      if (tag != DESC_TAG)
         fault = dac_pkg::FLT_TAG;
      else if (idx >= length)
         fault = dac_pkg::FLT_BOUNDS;
      else if (!present)
         fault = dac_pkg::FLT_ABSENT;
      else
         fault = dac_pkg::FLT_NONE;
   end
endmodule

// File: rtl/dac_lane_split.sv
// Turns an element index into a word offset and a character lane.
module dac_lane_split #(
   parameter int WORD_W = 48,
   parameter int LEN_W  = 20,
   parameter int LANE_W = 4
) (
   input  logic [LEN_W-1:0]  idx,
   input  dac_pkg::mode_e    mode,
   output logic [LEN_W-1:0]  offset,
   output logic [LANE_W-1:0] lane
);
   logic [LEN_W-1:0]  off_m  [4];
   logic [LANE_W-1:0] lane_m [4];

   assign off_m[0]  = idx;
   assign lane_m[0] = '0;

   // Modes 1..3: characters of 4, 6 and 8 bits.
   for (genvar m = 1; m < 4; m++) begin : g_char
      localparam int CH_BITS = 2 * m + 2;
      localparam int CPW     = WORD_W / CH_BITS;
      assign off_m[m]  = idx / LEN_W'(CPW);
      assign lane_m[m] = LANE_W'(idx % LEN_W'(CPW));
   end

   assign offset = off_m[mode];
   assign lane   = lane_m[mode];
endmodule

// File: rtl/dac_addr_gen.sv
// Adds the word offset to the segment base, wrapping at the address width.
module dac_addr_gen #(
   parameter int ADDR_W = 20,
   parameter int LEN_W  = 20
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [LEN_W-1:0]  offset,
   output logic [ADDR_W-1:0] addr
);
   assign addr = base + ADDR_W'(offset);
endmodule

// File: rtl/dac_top.sv
module dac_top #(
   parameter int WORD_W = 48,
   parameter int TAG_W  = 3,
   parameter int ADDR_W = 20,
   parameter int LEN_W  = 20,
   parameter logic [TAG_W-1:0] DESC_TAG = 3'd5,
   parameter int LANE_W = $clog2(WORD_W / 4)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [TAG_W-1:0]  desc_tag,
   input  logic [WORD_W-1:0] desc_word,
   input  logic [LEN_W-1:0]  index,
   output logic              rsp_valid,
   output logic [1:0]        rsp_fault,
   output logic [ADDR_W-1:0] rsp_addr,
   output logic [LANE_W-1:0] rsp_lane
);
   localparam int USED_W = ADDR_W + LEN_W + 3;

   initial begin
      if (WORD_W % 24 != 0)
         $fatal(1, "WORD_W must hold a whole number of 4, 6 and 8 bit characters");
      if (USED_W > WORD_W)
         $fatal(1, "descriptor fields do not fit in WORD_W");
      if ((1 << LANE_W) < WORD_W / 4)
         $fatal(1, "LANE_W too narrow for the 4 bit character count");
   end

   logic [ADDR_W-1:0] base;
   dac_pkg::mode_e    mode;
   dac_pkg::fault_e   fault;
   logic [LEN_W-1:0]  offset;
   logic [LANE_W-1:0] lane;
   logic [ADDR_W-1:0] addr;

   dac_field_decode #(
      .WORD_W(WORD_W), .TAG_W(TAG_W), .ADDR_W(ADDR_W),
      .LEN_W(LEN_W), .DESC_TAG(DESC_TAG)
   ) u_decode (
      .tag(desc_tag), .word(desc_word), .idx(index),
      .base(base), .mode(mode), .fault(fault)
   );

   dac_lane_split #(
      .WORD_W(WORD_W), .LEN_W(LEN_W), .LANE_W(LANE_W)
   ) u_split (
      .idx(index), .mode(mode), .offset(offset), .lane(lane)
   );

   dac_addr_gen #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W)
   ) u_addr (
      .base(base), .offset(offset), .addr(addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_fault <= '0;
         rsp_addr  <= '0;
         rsp_lane  <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_fault <= fault;
            if (fault == dac_pkg::FLT_NONE) begin
               rsp_addr <= addr;
               rsp_lane <= lane;
            end else begin
               rsp_addr <= '0;
               rsp_lane <= '0;
            end
         end
      end
   end
endmodule

// File: rtl/dac_checker.sv
module dac_checker #(
   parameter int WORD_W = 48,
   parameter int TAG_W  = 3,
   parameter int ADDR_W = 20,
   parameter int LEN_W  = 20,
   parameter logic [TAG_W-1:0] DESC_TAG = 3'd5,
   parameter int LANE_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [TAG_W-1:0]  desc_tag,
   input logic [WORD_W-1:0] desc_word,
   input logic [LEN_W-1:0]  index,
   input logic              rsp_valid,
   input logic [1:0]        rsp_fault,
   input logic [ADDR_W-1:0] rsp_addr,
   input logic [LANE_W-1:0] rsp_lane
);
   logic [ADDR_W-1:0] c_base;
   logic [LEN_W-1:0]  c_len;
   logic              c_pres;
   logic [1:0]        c_mode;
   logic              c_tag_ok;
   logic              chk_unused;

   assign c_base   = desc_word[ADDR_W-1:0];
   assign c_len    = desc_word[ADDR_W +: LEN_W];
   assign c_pres   = desc_word[ADDR_W + LEN_W];
   assign c_mode   = desc_word[ADDR_W + LEN_W + 1 +: 2];
   assign c_tag_ok = (desc_tag == DESC_TAG);
   assign chk_unused = ^desc_word;

   assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   assert_tag_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !c_tag_ok |=> rsp_fault == 2'd1);

   assert_bounds_R3: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && c_tag_ok && (index >= c_len) |=> rsp_fault == 2'd2);

   assert_absent_R4: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && c_tag_ok && (index < c_len) && !c_pres |=> rsp_fault == 2'd3);

   assert_word_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && c_tag_ok && (index < c_len) && c_pres && (c_mode == 2'd0)
      |=> rsp_fault == 2'd0 && rsp_lane == '0 &&
          rsp_addr == $past(c_base + ADDR_W'(index)));

   assert_lane_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_fault == 2'd0 |-> 32'(rsp_lane) < WORD_W / 4);

   assert_fault_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_fault != 2'd0 |-> rsp_addr == '0 && rsp_lane == '0);
endmodule

bind dac_top dac_checker #(
   .WORD_W(WORD_W), .TAG_W(TAG_W), .ADDR_W(ADDR_W),
   .LEN_W(LEN_W), .DESC_TAG(DESC_TAG), .LANE_W(LANE_W)
) u_dac_checker (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .desc_tag(desc_tag),
   .desc_word(desc_word), .index(index), .rsp_valid(rsp_valid),
   .rsp_fault(rsp_fault), .rsp_addr(rsp_addr), .rsp_lane(rsp_lane)
);

// File: tb/dac_top_bench.sv
module dac_top_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  desc_tag = 3'd0;
   logic [47:0] desc_word = 48'd0;
   logic [19:0] index = 20'd0;
   logic        rsp_valid;
   logic [1:0]  rsp_fault;
   logic [19:0] rsp_addr;
   logic [3:0]  rsp_lane;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // Expected-response queue: one entry per clock.
   bit    q_valid [$];
   bit    q_data  [$];
   int    q_fault [$];
   int    q_addr  [$];
   int    q_lane  [$];
   string q_tag   [$];

   always #(CLK_PERIOD / 2) clk = ~clk;

   dac_top u_dac_top (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .desc_tag(desc_tag),
      .desc_word(desc_word), .index(index), .rsp_valid(rsp_valid),
      .rsp_fault(rsp_fault), .rsp_addr(rsp_addr), .rsp_lane(rsp_lane)
   );

   function automatic logic [47:0] mk_desc(int base, int len, bit pres, int mode, int upper);
      logic [47:0] w;
      w = '0;
      w[19:0]  = 20'(base);
      w[39:20] = 20'(len);
      w[40]    = pres;
      w[42:41] = 2'(mode);
      w[47:43] = 5'(upper);
      return w;
   endfunction

   task automatic compare_front();
      bit ev, ed;
      int ef, ea, el;
      string t;
      if (q_valid.size() == 0) return;
      ev = q_valid.pop_front(); ed = q_data.pop_front();
      ef = q_fault.pop_front(); ea = q_addr.pop_front();
      el = q_lane.pop_front();  t  = q_tag.pop_front();
      checks++;
      if (rsp_valid !== ev) begin
         fails++;
         $display("FAIL %s: rsp_valid actual %0b expected %0b", t, rsp_valid, ev);
      end
      if (ed) begin
         checks++;
         if (rsp_fault !== 2'(ef) || rsp_addr !== 20'(ea) || rsp_lane !== 4'(el)) begin
            fails++;
            $display("FAIL %s: fault/addr/lane actual %0d/%0h/%0d expected %0d/%0h/%0d",
                     t, rsp_fault, rsp_addr, rsp_lane, ef, ea, el);
         end
      end
   endtask

   // Behavioural reference: one request in, the expected response out.
   task automatic step(bit v, int tag, logic [47:0] w, int idx, string force_tag);
      int base, len, mode, cpw, ef, ea, el;
      bit pres;
      string t;
      @(negedge clk);
      compare_front();
      req_valid = v; desc_tag = 3'(tag); desc_word = w; index = 20'(idx);
      base = int'(w[19:0]); len = int'(w[39:20]);
      pres = w[40]; mode = int'(w[42:41]);
      ea = 0; el = 0;
      if (tag != 5)          begin ef = 1; t = "R2/R9"; end
      else if (idx >= len)   begin ef = 2; t = "R3/R9"; end
      else if (!pres)        begin ef = 3; t = "R4/R9"; end
      else begin
         ef = 0;
         case (mode)
            0: begin cpw = 1;  t = "R5"; end
            1: begin cpw = 12; t = "R6"; end
            2: begin cpw = 8;  t = "R7"; end
            default: begin cpw = 6; t = "R8"; end
         endcase
         ea = (base + idx / cpw) % (1 << 20);
         el = (cpw == 1) ? 0 : idx % cpw;
      end
      if (!v) t = "R1";
      if (force_tag != "") t = force_tag;
      q_valid.push_back(v); q_data.push_back(v);
      q_fault.push_back(ef); q_addr.push_back(ea);
      q_lane.push_back(el);  q_tag.push_back(t);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual hung expected completion");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state, outputs all zero.
      q_valid.push_back(0); q_data.push_back(1); q_fault.push_back(0);
      q_addr.push_back(0);  q_lane.push_back(0); q_tag.push_back("R1");

      step(1, 2, mk_desc(100, 50, 1, 0, 0), 3, "");          // R2 wrong tag
      step(1, 7, mk_desc(100, 0, 0, 1, 0), 999, "");         // R2 beats bounds/absence
      step(1, 5, mk_desc(100, 0, 1, 0, 0), 0, "");           // R3 length zero
      step(1, 5, mk_desc(100, 40, 1, 2, 0), 40, "");         // R3 index == length
      step(1, 5, mk_desc(100, 40, 0, 2, 0), 40, "");         // R3 beats absence
      step(1, 5, mk_desc(100, 40, 0, 3, 0), 39, "");         // R4 absent
      step(1, 5, mk_desc(100, 40, 1, 0, 0), 39, "");         // R5 word mode
      step(1, 5, mk_desc(200, 100, 1, 1, 0), 11, "");        // R6 last lane of word
      step(1, 5, mk_desc(200, 100, 1, 1, 0), 12, "");        // R6 next word
      step(1, 5, mk_desc(200, 100, 1, 2, 0), 23, "");        // R7
      step(1, 5, mk_desc(200, 100, 1, 3, 0), 17, "");        // R8
      step(0, 5, mk_desc(200, 100, 1, 3, 0), 17, "");        // R1 idle
      step(1, 5, mk_desc(20'hFFFFF, 100, 1, 0, 0), 30, "R10");
      step(1, 5, mk_desc(20'hFFFFE, 200, 1, 1, 0), 40, "R10");
      step(1, 5, mk_desc(300, 60, 1, 2, 31), 50, "R11");
      step(1, 5, mk_desc(300, 60, 0, 2, 21), 50, "R11");

      for (int i = 0; i < 3000; i++) begin
         int tag, len, idx;
         tag = ($urandom % 10 < 7) ? 5 : int'($urandom % 8);
         len = int'($urandom % 300);
         idx = int'($urandom % 350);
         step(($urandom % 5) != 0, tag,
              mk_desc(int'($urandom % (1 << 20)), len, ($urandom % 7) != 0,
                      int'($urandom % 4), int'($urandom % 32)),
              idx, "");
      end
      @(negedge clk);
      compare_front();
      done = 1;
      finish_run();
   end
endmodule